// File: doc/BRIEF.md
# Vector Operand Fetch and Swizzle

This block sits at the front of a vector shader datapath. It takes one 128-bit instruction, given as four 32-bit words, and pulls out three 15-bit source specifiers. Each specifier names a register class: none, temp, input or constant. The block drives the matching read port, rearranges the four 32-bit components of the returned vector, and can flip their sign bits. The three finished operands appear on registered outputs one cycle after the instruction is accepted.

Constant reads can be direct or relative. A relative read adds a signed component of one of two address registers to the constant field of the instruction. A sum outside the constant file returns zero and raises a flag. The instruction has one input read port, so every input-type specifier in it must name the same input register. An instruction that breaks this rule is flagged as illegal, and no valid operands are issued for it.

All register-file reads are combinational and complete in the cycle the instruction is offered. Arithmetic, writeback and sequencing belong to other blocks.

Top module: `vsf_top`

## Requirements
- R1: The specifiers are assembled from the instruction words as follows. Source 0 is {word1[8:0], word2[31:26]}. Source 1 is word2[25:11]. Source 2 is {word2[10:0], word3[31:28]}. Operand 0, 1 and 2 come from source 0, 1 and 2 respectively.
- R2: Specifier bits 1:0 select the register class: 0 gives an all-zero vector, 1 reads temp register bits 5:2 on that source's own temp port, 2 reads input register bits 5:2, and 3 reads the constant file. A vector holds X in bits 31:0, Y in 63:32, Z in 95:64 and W in 127:96.
- R3: Specifier bits 13:12, 11:10, 9:8 and 7:6 choose the source component (0=X, 1=Y, 2=Z, 3=W) placed in result X, Y, Z and W respectively.
- R4: When specifier bit 14 is set, bit 31 of every result component is inverted after swizzling. This also applies to zero vectors.
- R5: When word3 bit 1 is clear, the constant address is word1[21:14]. No other word1 bits affect it.
- R6: When word3 bit 1 is set, the constant address is word1[21:14] plus a signed 10-bit address component. Word0 bit 24 picks address register 0 or 1, and word0 bits 2:1 pick its X, Y, Z or W component. The address bank packs register r, component c at bits [(r*4+c)*10 +: 10].
- R7: A relative constant address below 0 or above 255 makes every constant-class operand read as zero before negation. If at least one source is constant-class, this also pulses the out-of-range flag in the result cycle.
- R8: If two input-class specifiers name different input registers, the illegal flag pulses in the result cycle and the valid strobe stays low. Input-class specifiers that name the same register are legal. The input port is addressed by the lowest-numbered input-class source.
- R9: Operands, valid, illegal and out-of-range are updated on the clock edge that accepts an instruction. Exactly one of valid and illegal is high in the following cycle. With no instruction offered, all three strobes are low and the operands hold their values.
- R10: Synchronous reset clears the operands and all three strobes to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inst_vld | input | 1 | Instruction offered and accepted this cycle |
| inst_w0 | input | 32 | Instruction word 0 |
| inst_w1 | input | 32 | Instruction word 1 |
| inst_w2 | input | 32 | Instruction word 2 |
| inst_w3 | input | 32 | Instruction word 3 |
| tmp_raddr | output | 12 | Three 4-bit temp read addresses, source i at [4i +: 4] |
| tmp_rdata | input | 384 | Three temp read vectors, source i at [128i +: 128] |
| in_raddr | output | 4 | Input file read address |
| in_rdata | input | 128 | Input file read vector |
| cst_raddr | output | 8 | Constant file read address |
| cst_rdata | input | 128 | Constant file read vector |
| areg_bank | input | 80 | Two address registers of four signed 10-bit components |
| opnd0 | output | 128 | Operand from source 0 |
| opnd1 | output | 128 | Operand from source 1 |
| opnd2 | output | 128 | Operand from source 2 |
| opnd_vld | output | 1 | Operands valid for the accepted instruction |
| illegal_o | output | 1 | Input register conflict in the accepted instruction |
| oob_o | output | 1 | Relative constant address out of range |

## Verification
The two checks that can fire on the same instruction are the input-port conflict and the out-of-range relative constant. The bench provokes both at once with an instruction that has two input sources naming different registers and one constant source whose indexed address falls outside the file. The result cycle must show illegal and out-of-range both high and valid low. A reference model in the bench computes each flag separately from the specifiers and the address bank, so it would catch a design that lets one check suppress the other, or that drops the range check whenever the instruction is already illegal.

// File: rtl/vsf_pkg.sv
package vsf_pkg;

    parameter int DW         = 32;
    parameter int NCOMP      = 4;
    parameter int VW         = DW * NCOMP;
    parameter int NSRC       = 3;
    parameter int TMP_AW     = 4;
    parameter int IN_AW      = 4;
    parameter int CST_AW     = 8;
    parameter int AREG_W     = 10;
    parameter int NAREG      = 2;
    parameter int AREG_FLAT  = NAREG * NCOMP * AREG_W;
    parameter int SUM_W      = ((CST_AW > AREG_W) ? CST_AW : AREG_W) + 2;

    typedef enum logic [1:0] {
        RT_NONE  = 2'd0,
        RT_TEMP  = 2'd1,
        RT_INPUT = 2'd2,
        RT_CONST = 2'd3
    } rtype_e;

    // 15-bit source specifier, MSB first
    typedef struct packed {
        logic       neg;
        logic [1:0] sw_x;
        logic [1:0] sw_y;
        logic [1:0] sw_z;
        logic [1:0] sw_w;
        logic [3:0] regn;
        rtype_e     rtype;
    } spec_t;

    typedef struct packed {
        logic [CST_AW-1:0] cfield;
        logic              idx;
        logic              asel;
        logic [1:0]        acomp;
    } cctl_t;

    function automatic logic [VW-1:0] swz_neg(input logic [VW-1:0] v, input spec_t s);
        logic [1:0]    sel [NCOMP];
        logic [VW-1:0] r;
        sel[0] = s.sw_x;
        sel[1] = s.sw_y;
        sel[2] = s.sw_z;
        sel[3] = s.sw_w;
        r = '0;
        for (int c = 0; c < NCOMP; c++) begin
            r[c*DW +: DW] = v[int'(sel[c])*DW +: DW];
            r[c*DW + DW - 1] = r[c*DW + DW - 1] ^ s.neg;
        end
        return r;
    endfunction

endpackage

// File: rtl/vsf_spec_split.sv
module vsf_spec_split
    import vsf_pkg::*;
(
    input  logic [31:0]           w0,
    input  logic [31:0]           w1,
    input  logic [31:0]           w2,
    input  logic [31:0]           w3,
    output spec_t [NSRC-1:0]      specs,
    output cctl_t                 cctl
);
    always_comb begin
        specs[0]     = spec_t'({w1[8:0], w2[31:26]});
        specs[1]     = spec_t'(w2[25:11]);
        specs[2]     = spec_t'({w2[10:0], w3[31:28]});
        cctl.cfield  = w1[21:14];
        cctl.idx     = w3[1];
        cctl.asel    = w0[24];
        cctl.acomp   = w0[2:1];
    end
endmodule

// File: rtl/vsf_const_addr.sv
module vsf_const_addr
    import vsf_pkg::*;
(
    input  cctl_t               cctl,
    input  logic [AREG_FLAT-1:0] areg_bank,
    input  logic                any_const,
    output logic [CST_AW-1:0]   cst_raddr,
    output logic                cst_oob
);
    localparam int PICK_W = $clog2(NAREG * NCOMP);

    logic [PICK_W-1:0]  pick;
    logic [AREG_W-1:0]  offs;
    logic [SUM_W-1:0]   sum;
    logic               in_range;

    always_comb begin
        pick     = {cctl.asel, cctl.acomp};
        offs     = areg_bank[int'(pick)*AREG_W +: AREG_W];
        sum      = {{(SUM_W-CST_AW){1'b0}}, cctl.cfield}
                 + {{(SUM_W-AREG_W){offs[AREG_W-1]}}, offs};
        in_range = (sum[SUM_W-1:CST_AW] == '0);
        if (cctl.idx) begin
            cst_raddr = sum[CST_AW-1:0];
            cst_oob   = any_const & ~in_range;
        end else begin
            cst_raddr = cctl.cfield;
            cst_oob   = 1'b0;
        end
    end
endmodule

// File: rtl/vsf_input_arb.sv
module vsf_input_arb
    import vsf_pkg::*;
(
    input  spec_t [NSRC-1:0]  specs,
    output logic [IN_AW-1:0]  in_raddr,
    output logic              conflict,
    output logic              any_const
);
    always_comb begin
        logic found;
        found     = 1'b0;
        in_raddr  = '0;
        conflict  = 1'b0;
        any_const = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (specs[i].rtype == RT_CONST) any_const = 1'b1;
            if (specs[i].rtype == RT_INPUT) begin
                if (!found) begin
                    found    = 1'b1;
                    in_raddr = specs[i].regn[IN_AW-1:0];
                end else if (in_raddr != specs[i].regn[IN_AW-1:0]) begin
                    conflict = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/vsf_src_lane.sv
module vsf_src_lane
    import vsf_pkg::*;
(
    input  spec_t          spec,
    input  logic [VW-1:0]  tmp_vec,
    input  logic [VW-1:0]  in_vec,
    input  logic [VW-1:0]  cst_vec,
    input  logic           cst_oob,
    output logic [VW-1:0]  opnd
);
    logic [VW-1:0] base;

    always_comb begin
        unique case (spec.rtype)
            RT_TEMP:  base = tmp_vec;
            RT_INPUT: base = in_vec;
            RT_CONST: base = cst_oob ? '0 : cst_vec;
            default:  base = '0;
        endcase
        opnd = swz_neg(base, spec);
    end
endmodule

// File: rtl/vsf_top.sv
module vsf_top
    import vsf_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      inst_vld,
    input  logic [31:0]               inst_w0,
    input  logic [31:0]               inst_w1,
    input  logic [31:0]               inst_w2,
    input  logic [31:0]               inst_w3,
    output logic [NSRC*TMP_AW-1:0]    tmp_raddr,
    input  logic [NSRC*VW-1:0]        tmp_rdata,
    output logic [IN_AW-1:0]          in_raddr,
    input  logic [VW-1:0]             in_rdata,
    output logic [CST_AW-1:0]         cst_raddr,
    input  logic [VW-1:0]             cst_rdata,
    input  logic [AREG_FLAT-1:0]      areg_bank,
    output logic [VW-1:0]             opnd0,
    output logic [VW-1:0]             opnd1,
    output logic [VW-1:0]             opnd2,
    output logic                      opnd_vld,
    output logic                      illegal_o,
    output logic                      oob_o
);
    spec_t [NSRC-1:0] specs;
    cctl_t            cctl;
    logic             conflict;
    logic             any_const;
    logic             cst_oob;
    logic [VW-1:0]    lane_out [NSRC];
    logic [VW-1:0]    opnd_q   [NSRC];

    vsf_spec_split i_split (
        .w0    (inst_w0),
        .w1    (inst_w1),
        .w2    (inst_w2),
        .w3    (inst_w3),
        .specs (specs),
        .cctl  (cctl)
    );

    vsf_input_arb i_arb (
        .specs     (specs),
        .in_raddr  (in_raddr),
        .conflict  (conflict),
        .any_const (any_const)
    );

    vsf_const_addr i_caddr (
        .cctl      (cctl),
        .areg_bank (areg_bank),
        .any_const (any_const),
        .cst_raddr (cst_raddr),
        .cst_oob   (cst_oob)
    );

    for (genvar g = 0; g < NSRC; g++) begin : g_lane
        assign tmp_raddr[g*TMP_AW +: TMP_AW] = specs[g].regn[TMP_AW-1:0];

        vsf_src_lane i_lane (
            .spec    (specs[g]),
            .tmp_vec (tmp_rdata[g*VW +: VW]),
            .in_vec  (in_rdata),
            .cst_vec (cst_rdata),
            .cst_oob (cst_oob),
            .opnd    (lane_out[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            opnd_vld  <= 1'b0;
            illegal_o <= 1'b0;
            oob_o     <= 1'b0;
            for (int i = 0; i < NSRC; i++) opnd_q[i] <= '0;
        end else begin
            opnd_vld  <= inst_vld & ~conflict;
            illegal_o <= inst_vld & conflict;
            oob_o     <= inst_vld & cst_oob;
            if (inst_vld) begin
                for (int i = 0; i < NSRC; i++) opnd_q[i] <= lane_out[i];
            end
        end
    end

    assign opnd0 = opnd_q[0];
    assign opnd1 = opnd_q[1];
    assign opnd2 = opnd_q[2];

endmodule

// File: rtl/vsf_chk.sv
module vsf_chk
    import vsf_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   inst_vld,
    input logic [31:0]            inst_w1,
    input logic [31:0]            inst_w2,
    input logic [31:0]            inst_w3,
    input logic [IN_AW-1:0]       in_raddr,
    input logic [CST_AW-1:0]      cst_raddr,
    input logic [VW-1:0]          opnd0,
    input logic [VW-1:0]          opnd1,
    input logic [VW-1:0]          opnd2,
    input logic                   opnd_vld,
    input logic                   illegal_o,
    input logic                   oob_o
);
    AST_VLD_NOT_WITH_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
        !(opnd_vld && illegal_o)); // R8

    AST_ONE_RESULT_PER_INST: assert property (@(posedge clk) disable iff (rst)
        inst_vld |=> (opnd_vld ^ illegal_o)); // R9

    AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        !inst_vld |=> (!opnd_vld && !illegal_o && !oob_o)); // R9

    AST_IDLE_OPND_HOLD: assert property (@(posedge clk) disable iff (rst)
        !inst_vld |=> ($stable(opnd0) && $stable(opnd1) && $stable(opnd2))); // R9

    AST_OOB_ONLY_INDEXED: assert property (@(posedge clk) disable iff (rst)
        oob_o |-> $past(inst_w3[1])); // R7

    AST_SRC0_INPUT_ADDR: assert property (@(posedge clk) disable iff (rst)
        (inst_vld && inst_w2[27:26] == 2'd2) |-> (in_raddr == inst_w2[31:28])); // R2

    AST_DIRECT_CONST_ADDR: assert property (@(posedge clk) disable iff (rst)
        (inst_vld && !inst_w3[1]) |-> (cst_raddr == inst_w1[21:14])); // R5

endmodule

bind vsf_top vsf_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .inst_vld  (inst_vld),
    .inst_w1   (inst_w1),
    .inst_w2   (inst_w2),
    .inst_w3   (inst_w3),
    .in_raddr  (in_raddr),
    .cst_raddr (cst_raddr),
    .opnd0     (opnd0),
    .opnd1     (opnd1),
    .opnd2     (opnd2),
    .opnd_vld  (opnd_vld),
    .illegal_o (illegal_o),
    .oob_o     (oob_o)
);

// File: tb/test_vsf_top.sv
module test_vsf_top;
    import vsf_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                    rst;
    logic                    inst_vld;
    logic [31:0]             inst_w0, inst_w1, inst_w2, inst_w3;
    logic [NSRC*TMP_AW-1:0]  tmp_raddr;
    logic [NSRC*VW-1:0]      tmp_rdata;
    logic [IN_AW-1:0]        in_raddr;
    logic [VW-1:0]           in_rdata;
    logic [CST_AW-1:0]       cst_raddr;
    logic [VW-1:0]           cst_rdata;
    logic [AREG_FLAT-1:0]    areg_bank;
    logic [VW-1:0]           opnd0, opnd1, opnd2;
    logic                    opnd_vld, illegal_o, oob_o;

    int nchk  = 0;
    int nfail = 0;
    int areg_v [8];

    vsf_top i_vsf_top (.*);

    function automatic logic [31:0] fval(input int kind, input int r, input int c);
        return 32'(kind * 32'h1000_0000 + r * 256 + c);
    endfunction

    function automatic logic [VW-1:0] fvec(input int kind, input int r);
        logic [VW-1:0] v;
        for (int c = 0; c < NCOMP; c++) v[c*DW +: DW] = fval(kind, r, c);
        return v;
    endfunction

    always_comb begin
        for (int i = 0; i < NSRC; i++)
            tmp_rdata[i*VW +: VW] = fvec(1, int'(tmp_raddr[i*TMP_AW +: TMP_AW]));
        in_rdata  = fvec(2, int'(in_raddr));
        cst_rdata = fvec(3, int'(cst_raddr));
    end

    typedef struct {
        logic [NSRC*VW-1:0] ops;
        logic               vld;
        logic               ill;
        logic               oob;
        string              tag;
    } exp_t;

    exp_t exq [$];

    function automatic logic [14:0] sp(input bit neg, input int x, input int y,
                                       input int z, input int w, input int r, input int t);
        return {neg, 2'(x), 2'(y), 2'(z), 2'(w), 4'(r), 2'(t)};
    endfunction

    // driver: computes the expected result and offers one instruction
    task automatic issue(input logic [14:0] s0, input logic [14:0] s1, input logic [14:0] s2,
                         input int cf, input bit idx, input bit asel, input int acomp,
                         input string tag);
        logic [14:0] s [3];
        exp_t e;
        int   inum = -1;
        int   addr;
        bit   anyc = 0;
        bit   ill  = 0;
        bit   oob  = 0;
        s[0] = s0; s[1] = s1; s[2] = s2;
        for (int k = 0; k < 3; k++) begin
            if (s[k][1:0] == 2'd3) anyc = 1;
            if (s[k][1:0] == 2'd2) begin
                if (inum < 0) inum = int'(s[k][5:2]);
                else if (inum != int'(s[k][5:2])) ill = 1;
            end
        end
        addr = cf;
        if (idx) addr = cf + areg_v[int'(asel)*4 + acomp];
        if (idx && anyc && (addr < 0 || addr > 255)) oob = 1;
        for (int k = 0; k < 3; k++) begin
            for (int c = 0; c < 4; c++) begin
                int sel;
                logic [31:0] v;
                sel = int'(s[k][13-2*c -: 2]);
                case (int'(s[k][1:0]))
                    1:       v = fval(1, int'(s[k][5:2]), sel);
                    2:       v = fval(2, inum, sel);
                    3:       v = oob ? 32'h0 : fval(3, addr & 255, sel);
                    default: v = 32'h0;
                endcase
                if (s[k][14]) v[31] = ~v[31];
                e.ops[k*VW + c*DW +: DW] = v;
            end
        end
        e.vld = !ill;
        e.ill = ill;
        e.oob = oob;
        e.tag = tag;
        @(negedge clk);
        exq.push_back(e);
        inst_vld = 1'b1;
        inst_w0  = 32'h00A5_A5F0 | (32'(asel) << 24) | (32'(acomp & 3) << 1);
        inst_w1  = (32'(cf & 255) << 14) | 32'(s0[14:6]);
        inst_w2  = (32'(s0[5:0]) << 26) | (32'(s1) << 11) | 32'(s2[14:4]);
        inst_w3  = (32'(s2[3:0]) << 28) | (32'(idx) << 1) | 32'h0555_5550;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        inst_vld = 1'b0;
        inst_w0 = 32'hFFFF_FFFF; inst_w1 = 32'hFFFF_FFFF;
        inst_w2 = 32'hFFFF_FFFF; inst_w3 = 32'hFFFF_FFFF;
        repeat (n - 1) @(negedge clk);
    endtask

    // monitor: compares each result cycle against the scoreboard
    logic [NSRC*VW-1:0] held = '0;
    always @(posedge clk) begin
        logic acc;
        logic [NSRC*VW-1:0] act;
        acc = inst_vld && !rst;
        #5;
        act = {opnd2, opnd1, opnd0};
        if (!rst) begin
            nchk++;
            if (acc) begin
                if (exq.size() == 0) begin
                    nfail++;
                    $display("FAIL R9: result with empty scoreboard");
                end else begin
                    exp_t e;
                    e = exq.pop_front();
                    if (opnd_vld !== e.vld || illegal_o !== e.ill || oob_o !== e.oob ||
                        (e.vld && act !== e.ops)) begin
                        nfail++;
                        $display("FAIL %s: vld/ill/oob=%b%b%b ops=%h expected %b%b%b ops=%h",
                                 e.tag, opnd_vld, illegal_o, oob_o, act,
                                 e.vld, e.ill, e.oob, e.ops);
                    end
                end
            end else begin
                if (opnd_vld !== 1'b0 || illegal_o !== 1'b0 || oob_o !== 1'b0 || act !== held) begin
                    nfail++;
                    $display("FAIL R9 idle: vld/ill/oob=%b%b%b ops=%h expected 000 ops=%h",
                             opnd_vld, illegal_o, oob_o, act, held);
                end
            end
            held = act;
        end
    end

    initial begin
        #(20 * 100000);
        nfail++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", nfail, nchk);
        $finish;
    end

    initial begin
        areg_v = '{5, -3, 250, -256, 0, 100, -1, 511};
        for (int i = 0; i < 8; i++) areg_bank[i*AREG_W +: AREG_W] = AREG_W'(areg_v[i]);
        rst = 1'b1;
        inst_vld = 1'b0;
        inst_w0 = '0; inst_w1 = '0; inst_w2 = '0; inst_w3 = '0;
        repeat (3) @(negedge clk);
        // R10 reset state
        nchk++;
        if ({opnd2, opnd1, opnd0} !== '0 || opnd_vld !== 1'b0 || illegal_o !== 1'b0 || oob_o !== 1'b0) begin
            nfail++;
            $display("FAIL R10: outputs=%h strobes=%b%b%b expected all zero",
                     {opnd2, opnd1, opnd0}, opnd_vld, illegal_o, oob_o);
        end
        rst = 1'b0;

        issue(sp(0,0,1,2,3,3,1),  sp(0,0,1,2,3,7,1),  sp(0,0,1,2,3,15,1), 0, 0, 0, 0, "R1 temp identity");
        issue(sp(0,3,2,1,0,5,1),  sp(0,0,0,0,0,9,1),  sp(0,2,2,3,1,12,1), 0, 0, 0, 0, "R3 swizzle");
        issue(sp(1,0,1,2,3,4,1),  sp(1,3,3,3,3,4,1),  sp(0,1,0,3,2,0,1),  0, 0, 0, 0, "R4 negate");
        issue(sp(0,0,1,2,3,6,2),  sp(0,3,1,0,2,0,3),  sp(1,0,1,2,3,0,0),  77, 0, 0, 0, "R2 R5 mixed classes");
        issue(sp(0,1,1,1,1,0,3),  sp(1,2,3,0,1,0,3),  sp(0,3,2,1,0,9,3),  200, 0, 1, 3, "R5 direct const");
        idle(2);
        issue(sp(0,0,1,2,3,0,3),  sp(0,0,1,2,3,2,1),  sp(1,3,2,1,0,0,3),  10, 1, 0, 0, "R6 r0.x offset");
        issue(sp(0,0,1,2,3,0,3),  sp(0,0,0,0,0,0,0),  sp(0,0,1,2,3,0,0),  3,  1, 0, 1, "R6 low edge 0");
        issue(sp(0,0,1,2,3,0,3),  sp(0,0,0,0,0,0,0),  sp(0,0,1,2,3,0,0),  155, 1, 1, 1, "R6 high edge 255");
        issue(sp(0,1,2,3,0,0,3),  sp(0,0,1,2,3,1,1),  sp(0,0,0,0,0,0,0),  5,  1, 0, 2, "R6 r0.z to 255");
        issue(sp(0,0,1,2,3,0,3),  sp(0,0,1,2,3,8,1),  sp(1,0,1,2,3,0,3),  2,  1, 0, 1, "R7 below zero");
        issue(sp(0,0,1,2,3,0,3),  sp(0,0,1,2,3,0,2),  sp(0,0,1,2,3,0,0),  156, 1, 1, 1, "R7 above 255");
        issue(sp(0,0,1,2,3,0,3),  sp(0,0,1,2,3,0,0),  sp(0,0,1,2,3,0,0),  200, 1, 1, 3, "R7 r1.w high");
        issue(sp(0,0,1,2,3,0,3),  sp(0,0,1,2,3,0,0),  sp(0,0,1,2,3,0,0),  0,  1, 1, 2, "R7 r1.z negative");
        issue(sp(0,0,1,2,3,5,1),  sp(0,0,1,2,3,0,1),  sp(0,0,1,2,3,0,0),  0,  1, 1, 3, "R7 no const no flag");
        idle(1);
        issue(sp(0,0,1,2,3,3,2),  sp(0,0,1,2,3,5,2),  sp(0,0,1,2,3,0,1),  0, 0, 0, 0, "R8 input conflict");
        issue(sp(0,0,1,2,3,3,2),  sp(1,3,2,1,0,3,2),  sp(0,0,1,2,3,1,1),  0, 0, 0, 0, "R8 same input legal");
        issue(sp(0,0,1,2,3,0,0),  sp(0,0,1,2,3,11,2), sp(0,0,1,2,3,4,2),  0, 0, 0, 0, "R8 conflict src2");
        issue(sp(0,0,1,2,3,1,2),  sp(0,0,1,2,3,0,3),  sp(0,0,1,2,3,2,2),  255, 1, 0, 0, "R7 R8 both flags");
        issue(sp(0,0,1,2,3,0,3),  sp(0,0,1,2,3,0,2),  sp(0,0,1,2,3,0,3),  250, 1, 0, 1, "R6 after flags");
        idle(4);

        nchk++;
        if (exq.size() != 0) begin
            nfail++;
            $display("FAIL R9: %0d results missing, expected 0", exq.size());
        end
        $display("Result: errors=%0d of %0d checks", nfail, nchk);
        $finish;
    end

endmodule